// File: doc/BRIEF.md
# NAND Register-Window Width Adapter

This block sits behind one chip select of an external memory controller. It turns a single processor access into the string of device I/O cycles that a NAND part needs. The access may be 1, 2 or 4 bytes wide. It goes through one of three small register windows: one for commands, one for addresses and one for data. Each device I/O cycle is a strobe-and-ready handshake. A write sets the latch-enable line that belongs to its window, either the command latch or the address latch. Data accesses set neither.

The attached device is 8 or 16 bits wide, as given by a configuration input. A wide write is split into device cycles, least significant part first. A wide read is built up from device cycles in the same order. When the chip select is not set up as a NAND device, the windows do nothing: writes are dropped and reads return zero. Accesses to any other offset of the chip-select stride belong to configuration registers that accept only full-word accesses. The adapter completes them at once and flags any narrower access as an error.

The processor side presents one request per transfer. It then waits for the single-cycle completion pulse, while the busy output shows that device cycles are still in progress.

Top module: `nand_port_adapter`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_done`, `cpu_err`, `nand_cle`, `nand_ale`, `nand_we` and `nand_re` are all low.
- R2: For a write to the command window (stride offsets 0x1C..0x1F), `nand_cle` is high and `nand_ale` is low on every device cycle. For a write to the address window (0x20..0x23), `nand_ale` is high and `nand_cle` is low. For the data window (0x24..0x27), both are low. The two latch lines never rise together, hold steady through an access, and are low whenever the block is not busy.
- R3: With an 8-bit device (`cfg_wide`=0), a write issues one device cycle per byte of the access. Byte 0 goes first, on `nand_dout[7:0]`, and `nand_dout[15:8]` is 0. The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.
- R4: With a 16-bit device (`cfg_wide`=1), a 1-byte or 2-byte write issues one cycle carrying `cpu_wdata[15:0]` unchanged. A 4-byte write issues two cycles: bits [15:0] first, then bits [31:16].
- R5: With an 8-bit device, a data-window read of N bytes issues N read cycles. The k-th returned `nand_din[7:0]` lands in `cpu_rdata[8k+7:8k]`, and all higher bytes are 0.
- R6: With a 16-bit device, a 1-byte read issues one cycle and returns `nand_din[7:0]` with bits above 7 cleared. A 2-byte read returns the full word. A 4-byte read issues two cycles, with the first word in [15:0] and the second in [31:16].
- R7: When `cfg_is_nand` is 0, no window access produces any device cycle. Such a read completes with `cpu_rdata` = 0.
- R8: An access to an offset outside the three windows produces no device cycle. It completes one cycle after acceptance, with `cpu_err` high only if its size code is 0 or 1. Window accesses never raise `cpu_err`. A read of the command or address window produces no device cycle and returns 0.
- R9: While a device strobe is high and `nand_rdy` is low, the strobe and `nand_dout` hold their values. `cpu_busy` stays high until the handshake of the last cycle, and `cpu_done` pulses for one cycle as `cpu_busy` falls. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, sampled when not busy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_off | input | 6 | Byte offset inside the chip-select stride |
| cpu_size | input | 2 | 0 = byte, 1 = halfword, 2 or 3 = word |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Device cycles of the current access are running |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Width error, valid with `cpu_done` |
| cpu_rdata | output | 32 | Read result, valid from `cpu_done` until the next request |
| cfg_is_nand | input | 1 | Chip select is configured as a NAND device |
| cfg_wide | input | 1 | 0 = 8-bit device, 1 = 16-bit device |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we | output | 1 | Write strobe |
| nand_re | output | 1 | Read strobe |
| nand_dout | output | 16 | Data to the device |
| nand_din | input | 16 | Data from the device |
| nand_rdy | input | 1 | Device completes the current cycle |

## Verification
The bench goes after each combination of access size and device width. A wrong cycle count shows up as a missing or extra handshake against the expected queue. Byte-order errors show up as swapped lanes in `nand_dout` or `cpu_rdata`. A 1-byte read from a 16-bit device must clear its upper byte; leaking it would corrupt `cpu_rdata[15:8]`. Window-edge offsets (0x1F, 0x23, 0x27, 0x28), accesses to a non-NAND chip select, and a request injected while busy are each checked for phantom device cycles, and a latch line raised on the wrong window is caught on every handshake.

// File: rtl/nand_adapt_pkg.sv
package nand_adapt_pkg;

   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_CMD  = 2'd1,
      WIN_ADDR = 2'd2,
      WIN_DATA = 2'd3
   } win_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   localparam int PART_W = 3;

endpackage

// File: rtl/nand_win_decode.sv
module nand_win_decode
   import nand_adapt_pkg::*;
#(
   parameter int OFF_W     = 6,
   parameter int CMD_BASE  = 'h1C,
   parameter int ADDR_BASE = 'h20,
   parameter int DATA_BASE = 'h24,
   parameter int WIN_BYTES = 4
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        size,
   input  logic              we,
   input  logic              is_nand,
   input  logic              wide,
   output win_e              win,
   output logic              start_io,
   output logic              bad_width,
   output logic [PART_W-1:0] nparts
);

   function automatic logic in_win(input int o, input int base);
      return (o >= base) && (o < base + WIN_BYTES);
   endfunction

   always_comb begin
      int o;
      o = int'(off);
      if (in_win(o, CMD_BASE))       win = WIN_CMD;
      else if (in_win(o, ADDR_BASE)) win = WIN_ADDR;
      else if (in_win(o, DATA_BASE)) win = WIN_DATA;
      else                           win = WIN_NONE;
   end

   always_comb begin
      start_io  = is_nand && ((win == WIN_DATA) ||
                  (we && (win == WIN_CMD || win == WIN_ADDR)));
      bad_width = (win == WIN_NONE) && !size[1];
      if (wide)                nparts = size[1] ? PART_W'(2) : PART_W'(1);
      else if (size[1])        nparts = PART_W'(4);
      else if (size == SZ_HALF) nparts = PART_W'(2);
      else                     nparts = PART_W'(1);
   end

endmodule

// File: rtl/nand_lane_mux.sv
module nand_lane_mux
   import nand_adapt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEV_W  = 16
) (
   input  logic [DATA_W-1:0] wdata,
   input  logic [PART_W-1:0] idx,
   input  logic              wide,
   output logic [DEV_W-1:0]  dout
);

   localparam int NBYTES = DATA_W / 8;
   localparam int NHALF  = DATA_W / DEV_W;
   localparam int BSEL_W = $clog2(NBYTES);
   localparam int HSEL_W = (NHALF > 1) ? $clog2(NHALF) : 1;

   logic [DEV_W-1:0] byte_sel [NBYTES];
   logic [DEV_W-1:0] half_sel [NHALF];

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign byte_sel[g] = {{(DEV_W-8){1'b0}}, wdata[8*g +: 8]};
   end
   for (genvar h = 0; h < NHALF; h++) begin : g_half
      assign half_sel[h] = wdata[DEV_W*h +: DEV_W];
   end

   assign dout = wide ? half_sel[idx[HSEL_W-1:0]] : byte_sel[idx[BSEL_W-1:0]];

endmodule

// File: rtl/nand_rd_pack.sv
module nand_rd_pack
   import nand_adapt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap,
   input  logic [PART_W-1:0] idx,
   input  logic              wide,
   input  logic              narrow,
   input  logic [DEV_W-1:0]  din,
   output logic [DATA_W-1:0] rdata
);

   localparam int NBYTES = DATA_W / 8;
   localparam int BPH    = DEV_W / 8;

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      localparam int HI  = b % BPH;
      localparam int PRT = b / BPH;
      logic [7:0] wide_byte;
      assign wide_byte = (HI != 0 && narrow) ? 8'h00 : din[8*HI +: 8];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata[8*b +: 8] <= 8'h00;
         end else if (clear) begin
            rdata[8*b +: 8] <= 8'h00;
         end else if (cap) begin
            if (!wide && idx == PART_W'(b))
               rdata[8*b +: 8] <= din[7:0];
            else if (wide && idx == PART_W'(PRT))
               rdata[8*b +: 8] <= wide_byte;
         end
      end
   end

endmodule

// File: rtl/nand_port_adapter.sv
module nand_port_adapter
   import nand_adapt_pkg::*;
#(
   parameter int OFF_W     = 6,
   parameter int DATA_W    = 32,
   parameter int DEV_W     = 16,
   parameter int CMD_BASE  = 'h1C,
   parameter int ADDR_BASE = 'h20,
   parameter int DATA_BASE = 'h24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [OFF_W-1:0]  cpu_off,
   input  logic [1:0]        cpu_size,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              cpu_err,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              cfg_is_nand,
   input  logic              cfg_wide,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we,
   output logic              nand_re,
   output logic [DEV_W-1:0]  nand_dout,
   input  logic [DEV_W-1:0]  nand_din,
   input  logic              nand_rdy
);

   localparam int WIN_BYTES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("nand_port_adapter: DATA_W must be 32");
   end
   if (DEV_W != 16) begin : g_bad_dev_w
      $error("nand_port_adapter: DEV_W must be 16");
   end
   if ((1 << OFF_W) < DATA_BASE + WIN_BYTES) begin : g_bad_off_w
      $error("nand_port_adapter: OFF_W too small for window bases");
   end

   win_e              win;
   logic              start_io, bad_width;
   logic [PART_W-1:0] nparts;

   nand_win_decode #(
      .OFF_W(OFF_W), .CMD_BASE(CMD_BASE), .ADDR_BASE(ADDR_BASE),
      .DATA_BASE(DATA_BASE), .WIN_BYTES(WIN_BYTES)
   ) u_dec (
      .off(cpu_off), .size(cpu_size), .we(cpu_we), .is_nand(cfg_is_nand),
      .wide(cfg_wide), .win(win), .start_io(start_io),
      .bad_width(bad_width), .nparts(nparts)
   );

   logic              run_q, we_q, wide_q, narrow_q, cle_q, ale_q, done_q, err_q;
   logic [PART_W-1:0] idx_q, last_q;
   logic [DATA_W-1:0] wdata_q;
   logic              accept, step;

   assign accept = cpu_req && !run_q;
   assign step   = run_q && nand_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         we_q     <= 1'b0;
         wide_q   <= 1'b0;
         narrow_q <= 1'b0;
         cle_q    <= 1'b0;
         ale_q    <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         idx_q    <= '0;
         last_q   <= '0;
         wdata_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            run_q    <= start_io;
            we_q     <= cpu_we;
            wide_q   <= cfg_wide;
            narrow_q <= (cpu_size == SZ_BYTE);
            wdata_q  <= cpu_wdata;
            idx_q    <= '0;
            last_q   <= nparts - PART_W'(1);
            cle_q    <= start_io && (win == WIN_CMD);
            ale_q    <= start_io && (win == WIN_ADDR);
            done_q   <= !start_io;
            err_q    <= bad_width;
         end else if (step) begin
            if (idx_q == last_q) begin
               run_q  <= 1'b0;
               cle_q  <= 1'b0;
               ale_q  <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + PART_W'(1);
            end
         end
      end
   end

   nand_lane_mux #(.DATA_W(DATA_W), .DEV_W(DEV_W)) u_mux (
      .wdata(wdata_q), .idx(idx_q), .wide(wide_q), .dout(nand_dout)
   );

   nand_rd_pack #(.DATA_W(DATA_W), .DEV_W(DEV_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .clear(accept), .cap(step && !we_q),
      .idx(idx_q), .wide(wide_q), .narrow(narrow_q), .din(nand_din),
      .rdata(cpu_rdata)
   );

   assign cpu_busy = run_q;
   assign cpu_done = done_q;
   assign cpu_err  = done_q && err_q;
   assign nand_cle = cle_q;
   assign nand_ale = ale_q;
   assign nand_we  = run_q && we_q;
   assign nand_re  = run_q && !we_q;

   // R2
   cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R2
   latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_busy && $past(cpu_busy)) |-> ($stable(nand_cle) && $stable(nand_ale)));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> !(nand_cle || nand_ale || nand_we || nand_re));

   // R9
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((nand_we || nand_re) && !nand_rdy) |=>
         ($stable(nand_dout) && $stable(nand_we) && $stable(nand_re)));

   // R9
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_busy);

   // R7
   non_nand_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_busy && !cfg_is_nand) |=> (!cpu_busy && cpu_done));

endmodule

// File: tb/tb_nand_port_adapter.sv
module tb_nand_port_adapter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [5:0]  cpu_off = '0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_busy, cpu_done, cpu_err;
   logic [31:0] cpu_rdata;
   logic        cfg_is_nand = 1'b1, cfg_wide = 1'b0;
   logic        nand_cle, nand_ale, nand_we, nand_re;
   logic [15:0] nand_dout;
   logic [15:0] nand_din = '0;
   logic        nand_rdy = 1'b0;

   always #2.5 clk = ~clk;

   nand_port_adapter dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_off(cpu_off), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_err(cpu_err),
      .cpu_rdata(cpu_rdata), .cfg_is_nand(cfg_is_nand), .cfg_wide(cfg_wide),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we),
      .nand_re(nand_re), .nand_dout(nand_dout), .nand_din(nand_din),
      .nand_rdy(nand_rdy)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit inflight = 1'b0;
   bit finished = 1'b0;

   // expected device cycles: {care_dout, cle, ale, we, re, dout}
   logic [20:0] exp_q[$];
   logic [15:0] rd_q[$];
   int hs_cnt = 0;
   int wait_n = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected 0", cyc);
         summary();
      end
   end

   // device model and per-clock comparison
   always @(negedge clk) begin
      if (rst_n && !inflight)
         chk({cpu_busy, nand_cle, nand_ale, nand_we, nand_re} == 5'b0, "R2 idle",
             {27'b0, cpu_busy, nand_cle, nand_ale, nand_we, nand_re}, 32'h0);
      if (nand_rdy) begin
         nand_rdy <= 1'b0;
         wait_n = hs_cnt % 3;
      end else if (nand_we || nand_re) begin
         if (wait_n > 0) begin
            wait_n--;
         end else begin
            logic [20:0] e;
            logic [15:0] v;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 unexpected cycle", {27'b0, nand_cle, nand_ale,
                   nand_we, nand_re, 1'b0}, 32'h0);
            end else begin
               e = exp_q.pop_front();
               chk({nand_cle, nand_ale, nand_we, nand_re} == e[19:16],
                   "R2 ctl lines", {28'b0, nand_cle, nand_ale, nand_we, nand_re},
                   {28'b0, e[19:16]});
               if (e[20])
                  chk(nand_dout == e[15:0], "R3/R4 dout", {16'b0, nand_dout},
                      {16'b0, e[15:0]});
            end
            v = {8'(hs_cnt) ^ 8'h5A, 8'(hs_cnt) + 8'h81};
            if (nand_re) rd_q.push_back(v);
            nand_din <= v;
            nand_rdy <= 1'b1;
            hs_cnt++;
         end
      end
   end

   function automatic int win_of(input logic [5:0] o);
      if (o >= 6'h1C && o <= 6'h1F) return 1;
      if (o >= 6'h20 && o <= 6'h23) return 2;
      if (o >= 6'h24 && o <= 6'h27) return 3;
      return 0;
   endfunction

   task automatic access(input string req, input bit we, input logic [5:0] off,
                         input logic [1:0] sz, input logic [31:0] wd,
                         input bit is_nand, input bit wide, input bit poke);
      int w, n, bytes, it;
      bit act, bad;
      logic [31:0] exp_rd;
      w = win_of(off);
      bytes = sz[1] ? 4 : (sz == 2'd1 ? 2 : 1);
      act = is_nand && (w == 3 || (we && (w == 1 || w == 2)));
      bad = (w == 0) && !sz[1];
      n = act ? (wide ? (bytes == 4 ? 2 : 1) : bytes) : 0;
      for (int k = 0; k < n; k++) begin
         logic [15:0] d;
         d = wide ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
         exp_q.push_back({we, w == 1, w == 2, we, !we, d});
      end
      @(negedge clk);
      cfg_is_nand = is_nand;
      cfg_wide = wide;
      inflight = 1'b1;
      cpu_req = 1'b1; cpu_we = we; cpu_off = off; cpu_size = sz; cpu_wdata = wd;
      it = 0;
      forever begin
         @(negedge clk);
         it++;
         cpu_req = 1'b0;
         if (poke && it == 2 && cpu_busy) begin
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_off = 6'h1C;
            cpu_size = 2'd2; cpu_wdata = 32'hDEAD_BEEF;
         end
         if (cpu_done) break;
         if (it > 200) break;
      end
      chk(cpu_done == 1'b1, {req, " done"}, {31'b0, cpu_done}, 32'h1);
      chk(cpu_busy == 1'b0, "R9 busy at done", {31'b0, cpu_busy}, 32'h0);
      chk(exp_q.size() == 0, {req, " cycle count"}, exp_q.size(), 32'h0);
      exp_q.delete();
      chk(cpu_err == bad, {req, " R8 err"}, {31'b0, cpu_err}, {31'b0, bad});
      if (!we) begin
         exp_rd = 32'h0;
         if (act) begin
            for (int k = 0; k < n; k++) begin
               logic [15:0] v;
               v = (rd_q.size() != 0) ? rd_q.pop_front() : 16'h0;
               if (wide) exp_rd[16*k +: 16] = v;
               else      exp_rd[8*k +: 8] = v[7:0];
            end
            if (wide && bytes == 1) exp_rd[15:8] = 8'h00;
         end
         chk(cpu_rdata == exp_rd, {req, " rdata"}, cpu_rdata, exp_rd);
      end
      rd_q.delete();
      @(negedge clk);
      chk(cpu_done == 1'b0, "R9 done pulse width", {31'b0, cpu_done}, 32'h0);
      inflight = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk({cpu_busy, cpu_done, cpu_err, nand_cle, nand_ale, nand_we, nand_re} == 7'b0,
          "R1 reset", {25'b0, cpu_busy, cpu_done, cpu_err, nand_cle, nand_ale,
          nand_we, nand_re}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // 8-bit device: R2, R3
      access("R2 cmd byte",   1, 6'h1C, 2'd0, 32'h0000_0070, 1, 0, 0);
      access("R3 addr word",  1, 6'h20, 2'd2, 32'h4433_2211, 1, 0, 0);
      access("R3 data half",  1, 6'h24, 2'd1, 32'hFFFF_BEEF, 1, 0, 0);
      access("R2 cmd edge",   1, 6'h1F, 2'd1, 32'h0000_3130, 1, 0, 0);
      access("R2 addr edge",  1, 6'h23, 2'd3, 32'hA1B2_C3D4, 1, 0, 0);
      // R5
      access("R5 read byte",  0, 6'h24, 2'd0, 32'h0, 1, 0, 0);
      access("R5 read half",  0, 6'h25, 2'd1, 32'h0, 1, 0, 0);
      access("R5 read word",  0, 6'h27, 2'd2, 32'h0, 1, 0, 0);
      // 16-bit device: R4, R6
      access("R4 cmd byte",   1, 6'h1C, 2'd0, 32'h1234_ABCD, 1, 1, 0);
      access("R4 data half",  1, 6'h24, 2'd1, 32'h5555_9876, 1, 1, 0);
      access("R4 data word",  1, 6'h26, 2'd2, 32'hCAFE_F00D, 1, 1, 0);
      access("R4 addr word",  1, 6'h21, 2'd2, 32'h0102_0304, 1, 1, 0);
      access("R6 read byte",  0, 6'h24, 2'd0, 32'h0, 1, 1, 0);
      access("R6 read half",  0, 6'h24, 2'd1, 32'h0, 1, 1, 0);
      access("R6 read word",  0, 6'h24, 2'd2, 32'h0, 1, 1, 0);
      // R7
      access("R7 write",      1, 6'h24, 2'd2, 32'h7777_7777, 0, 0, 0);
      access("R7 cmd write",  1, 6'h1C, 2'd0, 32'h0000_00FF, 0, 1, 0);
      access("R7 read",       0, 6'h24, 2'd2, 32'h0, 0, 1, 0);
      // R8
      access("R8 cfg half",   1, 6'h04, 2'd1, 32'h1, 1, 0, 0);
      access("R8 cfg word",   1, 6'h18, 2'd2, 32'h1, 1, 0, 0);
      access("R8 past data",  0, 6'h28, 2'd0, 32'h0, 1, 0, 0);
      access("R8 cmd read",   0, 6'h1C, 2'd2, 32'h0, 1, 0, 0);
      access("R8 addr read",  0, 6'h22, 2'd0, 32'h0, 1, 1, 0);
      // R9: request while busy ignored
      access("R9 busy poke",  1, 6'h24, 2'd2, 32'h8877_6655, 1, 0, 1);
      access("R9 after poke", 0, 6'h24, 2'd1, 32'h0, 1, 0, 0);
      repeat (5) @(negedge clk);
      summary();
   end

endmodule